// File: doc/BRIEF.md
# Keyed Configuration Port

This block puts a configuration register space behind a two-address host port. Offset 0 is the index port and offset 1 is the data port. The space stays closed until the host writes the enter key to the index port in two consecutive index writes. While the space is open, an index-port write latches a register index, and the data port then reads or writes that register. A separate leave key, written to the index port, closes the space again. A static strap chooses between two key pairs.

Indexes below 0x30 are global and are served inside the block. These include a logical-device select register and a fixed chip-identification byte. Indexes from 0x30 up are forwarded to the selected logical device over a simple strobe bus. Each device has its own write strobe and read request, and a shared index and write-data bus. Each device returns a read byte in the same cycle. A parameter mask says which device numbers exist. The watchdog, for example, sits at device 8.

Top module: `cfg_port`

## Requirements
- R1: After a synchronous reset the space is closed, the latched index and device select are 0x00, `host_rdata` is 0xFF and no device strobe is active.
- R2: A single enter-key write to the index port leaves the space closed. Any other index-port write between the two enter writes restarts the sequence. Data-port writes do not restart it.
- R3: With `alt_key`=0 the enter key is 0x87. Two consecutive index-port writes (`host_addr`=0) of the enter key open the space. Data accesses then use `host_addr`=1.
- R4: While the space is open, an index-port write of the leave key (0xAA with `alt_key`=0) closes it and leaves the index unchanged. While the space is closed, data-port writes have no effect and data-port reads return 0xFF.
- R5: With `alt_key`=1 the key pair is 0x88 to enter and 0xBB to leave. The other pair then acts only as ordinary index values.
- R6: Index 0x07 is a read/write 8-bit logical-device select register.
- R7: Index 0x20 reads the parameter `CHIP_ID` (default 0x5A). Writes to it are ignored. Other global indexes below 0x30 read 0x00.
- R8: For an index of 0x30 or more, when the selected device exists, a data write raises only `dev_wr[sel]` in the cycle of `host_wr`, with `dev_idx` set to the index and `dev_wdata` set to the host byte. A data read raises only `dev_rd[sel]` and returns that device's byte.
- R9: A device whose number is at least `NUM_LDEV`, or whose bit in `DEV_PRESENT` is clear, gets no strobe and reads back 0xFF.
- R10: `host_rdata` loads on the clock edge that samples `host_rd` and holds between reads. When a read and a write fall in the same cycle, the read returns the state from before the write.
- R11: An index-port read returns the latched index while the space is open, and 0xFF while it is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_key | input | 1 | Static strap: 1 selects the alternate key pair |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| dev_wr | output | NUM_LDEV | Per-device write strobe |
| dev_rd | output | NUM_LDEV | Per-device read request |
| dev_idx | output | 8 | Register index presented to the devices |
| dev_wdata | output | 8 | Write byte presented to the devices |
| dev_rdata | input | NUM_LDEV*8 | Read bytes from all devices, device i in bits [8i+7:8i] |

## Verification
A read and a write can be issued in the same cycle. The case of interest is a write that changes state which the read depends on. The bench provokes this in two ways. It reads the index port while writing the leave key to it, and the read must still return the open-state index. It also reads the device select while overwriting it, and the read must return the old number. The behavioural model in the bench computes every read from the state it held before applying that cycle's write. The bench compares `host_rdata` and every device strobe against this model after each clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW = 8;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_t;
  localparam logic [DW-1:0] IDX_LDEV_SEL = 8'h07;
  localparam logic [DW-1:0] IDX_CHIP_ID  = 8'h20;
  localparam logic [DW-1:0] IDX_DEV_BASE = 8'h30;
  localparam logic [DW-1:0] KEY_ENTER_A  = 8'h87;
  localparam logic [DW-1:0] KEY_LEAVE_A  = 8'hAA;
  localparam logic [DW-1:0] KEY_ENTER_B  = 8'h88;
  localparam logic [DW-1:0] KEY_LEAVE_B  = 8'hBB;
  localparam logic [DW-1:0] RD_EMPTY     = 8'hFF;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          alt_key,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          is_open,
  output logic          idx_load
);
  key_state_t state_q;
  logic [DW-1:0] enter_k, leave_k;

  assign enter_k  = alt_key ? KEY_ENTER_B : KEY_ENTER_A;
  assign leave_k  = alt_key ? KEY_LEAVE_B : KEY_LEAVE_A;
  assign is_open  = (state_q == KS_OPEN);
  assign idx_load = key_wr && is_open && (key_data != leave_k);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_LOCKED;
    end else if (key_wr) begin
      case (state_q)
        KS_LOCKED: state_q <= (key_data == enter_k) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_q <= (key_data == enter_k) ? KS_OPEN : KS_LOCKED;
        default:   if (key_data == leave_k) state_q <= KS_LOCKED;
      endcase
    end
  end

  // R3
  open_needs_enter_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(is_open) |-> $past(key_wr && key_data == enter_k));

  // R4
  leave_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (is_open && key_wr && key_data == leave_k) |=> !is_open);

  // R2
  single_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (!is_open && key_wr && key_data != enter_k) |=> !is_open);
endmodule

// File: rtl/cfg_dev_router.sv
module cfg_dev_router
  import cfg_port_pkg::*;
#(
  parameter int              NUM_LDEV    = 16,
  parameter logic [NUM_LDEV-1:0] DEV_PRESENT = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fwd_en,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [DW-1:0]          sel,
  input  logic [NUM_LDEV*DW-1:0] dev_rdata,
  output logic [NUM_LDEV-1:0]    dev_wr,
  output logic [NUM_LDEV-1:0]    dev_rd,
  output logic [DW-1:0]          fwd_rdata
);
  logic [NUM_LDEV-1:0] hit;

  for (genvar i = 0; i < NUM_LDEV; i++) begin : g_dev
    if (DEV_PRESENT[i]) begin : g_on
      assign hit[i] = (sel == DW'(i));
    end else begin : g_off
      assign hit[i] = 1'b0;
    end
    assign dev_wr[i] = fwd_en && host_wr && hit[i];
    assign dev_rd[i] = fwd_en && host_rd && hit[i];
  end

  always_comb begin
    fwd_rdata = RD_EMPTY;
    for (int i = 0; i < NUM_LDEV; i++)
      if (hit[i]) fwd_rdata = dev_rdata[i*DW +: DW];
  end

  // R8
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dev_wr));
  // R8
  rd_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(dev_rd));
  // R9
  no_strobe_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (|(dev_wr | dev_rd)) |-> fwd_en);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_open,
  input  logic          idx_load,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] fwd_rdata,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] sel_q,
  output logic          fwd_en,
  output logic [DW-1:0] host_rdata
);
  logic [DW-1:0] rd_val;

  assign fwd_en = is_open && host_addr && (idx_q >= IDX_DEV_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sel_q <= '0;
    end else begin
      if (idx_load) idx_q <= host_wdata;
      if (host_wr && host_addr && is_open && idx_q == IDX_LDEV_SEL)
        sel_q <= host_wdata;
    end
  end

  always_comb begin
    if (!host_addr)                  rd_val = is_open ? idx_q : RD_EMPTY;
    else if (!is_open)               rd_val = RD_EMPTY;
    else if (idx_q == IDX_LDEV_SEL)  rd_val = sel_q;
    else if (idx_q == IDX_CHIP_ID)   rd_val = CHIP_ID;
    else if (idx_q < IDX_DEV_BASE)   rd_val = '0;
    else                             rd_val = fwd_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= RD_EMPTY;
    else if (host_rd) host_rdata <= rd_val;
  end

  // R4
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr && !is_open) |=> host_rdata == RD_EMPTY);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
  // R4
  sel_closed_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !is_open |=> $stable(sel_q));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter int                  NUM_LDEV    = 16,
  parameter logic [NUM_LDEV-1:0] DEV_PRESENT = 16'h0110,
  parameter logic [7:0]          CHIP_ID     = 8'h5A
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alt_key,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic                   host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic [NUM_LDEV-1:0]    dev_wr,
  output logic [NUM_LDEV-1:0]    dev_rd,
  output logic [7:0]             dev_idx,
  output logic [7:0]             dev_wdata,
  input  logic [NUM_LDEV*8-1:0]  dev_rdata
);
  logic          is_open, idx_load, fwd_en;
  logic [DW-1:0] idx_q, sel_q, fwd_rdata;

  cfg_key_fsm u_keys (
    .clk      (clk),
    .rst      (rst),
    .alt_key  (alt_key),
    .key_wr   (host_wr && !host_addr),
    .key_data (host_wdata),
    .is_open  (is_open),
    .idx_load (idx_load)
  );

  cfg_global_regs #(.CHIP_ID(CHIP_ID)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .is_open    (is_open),
    .idx_load   (idx_load),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .fwd_rdata  (fwd_rdata),
    .idx_q      (idx_q),
    .sel_q      (sel_q),
    .fwd_en     (fwd_en),
    .host_rdata (host_rdata)
  );

  cfg_dev_router #(.NUM_LDEV(NUM_LDEV), .DEV_PRESENT(DEV_PRESENT)) u_route (
    .clk       (clk),
    .rst       (rst),
    .fwd_en    (fwd_en),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .sel       (sel_q),
    .dev_rdata (dev_rdata),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd),
    .fwd_rdata (fwd_rdata)
  );

  assign dev_idx   = idx_q;
  assign dev_wdata = host_wdata;
endmodule

// File: tb/cfg_port_tb.sv
`timescale 1ns/1ps
module cfg_port_tb;
  localparam int          N    = 16;
  localparam logic [15:0] PRES = 16'h0110;
  localparam logic [7:0]  CHIP = 8'h5A;

  logic clk = 0, rst = 1, alt_key = 0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, dev_idx, dev_wdata;
  logic [N-1:0] dev_wr, dev_rd;
  logic [N*8-1:0] dev_rdata;

  int nchecks = 0, nerr = 0;
  bit done = 0;

  int m_state;
  logic [7:0] m_idx, m_sel, m_rd;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) dev_rdata[i*8 +: 8] = 8'(i * 8'h11) ^ dev_idx;

  cfg_port #(.NUM_LDEV(N), .DEV_PRESENT(PRES), .CHIP_ID(CHIP)) u_dut (
    .clk(clk), .rst(rst), .alt_key(alt_key), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata));

  function automatic bit present(input logic [7:0] s);
    return (s < N) && PRES[s[3:0]];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst = 1; alt_key = alt;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_state = 0; m_idx = 0; m_sel = 0; m_rd = 8'hFF;
    chk(host_rdata == 8'hFF, "R1", "rdata after reset", host_rdata, 8'hFF);
    chk(dev_wr == 0 && dev_rd == 0, "R1", "strobes after reset", {dev_wr, dev_rd}, 0);
  endtask

  // one host cycle; entered and left at a falling edge
  task automatic op(input logic w, input logic r, input logic a,
                    input logic [7:0] d, input string tag);
    logic [7:0] ek, lk, rv;
    logic [N-1:0] ew, er;
    bit fwd, open;
    ek = alt_key ? 8'h88 : 8'h87;
    lk = alt_key ? 8'hBB : 8'hAA;
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    #1;
    open = (m_state == 2);
    fwd = open && a && m_idx >= 8'h30 && present(m_sel);
    ew = (w && fwd) ? (N'(1) << m_sel[3:0]) : '0;
    er = (r && fwd) ? (N'(1) << m_sel[3:0]) : '0;
    chk(dev_wr == ew, tag, "dev_wr", 32'(dev_wr), 32'(ew));
    chk(dev_rd == er, tag, "dev_rd", 32'(dev_rd), 32'(er));
    if (ew != 0) begin
      chk(dev_idx == m_idx, tag, "dev_idx", dev_idx, m_idx);
      chk(dev_wdata == d, tag, "dev_wdata", dev_wdata, d);
    end
    if (!a)                rv = open ? m_idx : 8'hFF;
    else if (!open)        rv = 8'hFF;
    else if (m_idx == 8'h07) rv = m_sel;
    else if (m_idx == 8'h20) rv = CHIP;
    else if (m_idx < 8'h30)  rv = 8'h00;
    else if (present(m_sel)) rv = 8'(m_sel * 8'h11) ^ m_idx;
    else                     rv = 8'hFF;
    if (r) m_rd = rv;
    if (w && !a) begin
      case (m_state)
        0: m_state = (d == ek) ? 1 : 0;
        1: m_state = (d == ek) ? 2 : 0;
        default: if (d == lk) m_state = 0; else m_idx = d;
      endcase
    end else if (w && a && open && m_idx == 8'h07) begin
      m_sel = d;
    end
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0;
    chk(host_rdata == m_rd, tag, "host_rdata", host_rdata, m_rd);
    @(negedge clk);
  endtask

  task automatic wi(input logic [7:0] d, input string tag); op(1, 0, 0, d, tag); endtask
  task automatic wd(input logic [7:0] d, input string tag); op(1, 0, 1, d, tag); endtask
  task automatic rdd(input string tag); op(0, 1, 1, 8'h00, tag); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    rdd("R4");
    op(0, 1, 0, 8'h00, "R11");
    // R2 single key, broken sequence
    wi(8'h87, "R2"); rdd("R2");
    wi(8'h12, "R2"); wi(8'h87, "R2"); wd(8'h44, "R2"); rdd("R2");
    // R3 second key opens
    wi(8'h87, "R3"); op(0, 1, 0, 8'h00, "R11");
    // R6 device select
    wi(8'h07, "R6"); wd(8'h08, "R6"); rdd("R6");
    // R7 chip id and other globals
    wi(8'h20, "R7"); rdd("R7"); wd(8'h33, "R7"); rdd("R7");
    wi(8'h10, "R7"); rdd("R7");
    // R8 forwarding to device 8
    wi(8'h30, "R8"); wd(8'h55, "R8"); rdd("R8");
    wi(8'hF5, "R8"); wd(8'h3C, "R8"); rdd("R8");
    op(0, 0, 0, 8'h00, "R10");
    // R9 absent devices
    wi(8'h07, "R9"); wd(8'h03, "R9");
    wi(8'h30, "R9"); wd(8'h11, "R9"); rdd("R9");
    wi(8'h07, "R9"); wd(8'h18, "R9"); wi(8'h31, "R9"); rdd("R9");
    wi(8'h07, "R8"); wd(8'h04, "R8"); wi(8'h31, "R8"); rdd("R8"); wd(8'h77, "R8");
    // R10 read and write in the same cycle
    wi(8'h07, "R10"); op(1, 1, 1, 8'h08, "R10"); rdd("R10");
    op(1, 1, 0, 8'hAA, "R10"); op(0, 1, 0, 8'h00, "R11");
    // R4 closed: writes ignored
    wd(8'h02, "R4"); rdd("R4");
    wi(8'h87, "R4"); wi(8'h87, "R4"); rdd("R4");
    op(0, 0, 1, 8'h00, "R10");
    // R5 alternate pair
    do_reset(1);
    wi(8'h87, "R5"); wi(8'h87, "R5"); rdd("R5");
    wi(8'h88, "R5"); wi(8'h88, "R5"); op(0, 1, 0, 8'h00, "R5");
    wi(8'hAA, "R5"); op(0, 1, 0, 8'h00, "R5");
    wi(8'h07, "R5"); rdd("R5");
    wi(8'hBB, "R5"); rdd("R5"); op(0, 1, 0, 8'h00, "R5");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule